// File: doc/BRIEF.md
# MAC address table access engine

This block holds a small forwarding table of MAC address and VLAN pairs. The table is laid out as hashed buckets, and each bucket holds several bins. Software reaches the table through a byte-addressed register port. To use it, software loads a 48-bit MAC key and a VLAN key, then issues a command through an 8-bit control register. Bit 7 of that register starts the command and reads as busy until the command ends; it clears itself. Bit 0 picks the direction.

A read command copies every bin of the selected bucket into per-bin entry registers. Software then compares the MAC field of each valid bin against its key. A write command stores all per-bin entry registers back into the bucket selected by the loaded key. To delete an entry, software reads the bucket, clears the valid flag of one bin and writes the bucket back.

The command sequencer is a state machine with three states:
- `ST_IDLE` waits for a start.
- `ST_FETCH` copies one bin per cycle from memory into the entry registers.
- `ST_STORE` copies one bin per cycle from the entry registers into memory.

It has these transitions:
- start-read takes `ST_IDLE` to `ST_FETCH`.
- start-write takes `ST_IDLE` to `ST_STORE`.
- next-bin keeps `ST_FETCH` or `ST_STORE` in place while bins remain.
- last-bin returns `ST_FETCH` or `ST_STORE` to `ST_IDLE` after the fourth bin.

Top module: `mac_tbl_engine`

## Requirements
- R1: After reset, the control register reads 0x00 and every entry register reads 0. Every table bin is invalid, so a read command on any bucket returns data words of 0.
- R2: The register map is as follows. Control is at 0x00, the MAC key (48 bits) is at 0x02 and the VLAN key (16 bits) is at 0x08. Bins are numbered 1 to 4. Bin n has its key word at 0x10*n and its data word at 0x10*n+0x08. Write data is aligned to the register's bit 0. Byte enable bit i gates byte i, and bytes beyond the register's width are dropped. A read presented in one cycle returns its value on bus_rdata in the next cycle, zero-extended. Unmapped addresses read 0.
- R3: A key word keeps bits 59:0 and reads 0 in bits 63:60. Bits 47:0 hold the MAC, with the first octet in 47:40, and bits 59:48 hold the VLAN ID. A data word keeps only these fields: port in 8:0, traffic class in 12:11, age in bit 14, static in bit 15 and valid in bit 16. All other bits read 0.
- R4: A control write with byte enable 0 set and bit 7 of the data set starts a command. Bit 0 of the same write selects the operation: 1 means read and 0 means write. Bit 7 reads 1 for reads presented in the four cycles after the start write, and reads 0 from the fifth cycle on. Bit 0 reads back the last operation selected.
- R5: A read command copies all four bins of the selected bucket into the entry registers of bins 1 to 4.
- R6: A write command stores all four entry registers into the selected bucket, and a later read command on the same bucket returns them. A bin written back with its valid flag (bit 16) clear reads back as invalid.
- R7: The bucket index is the XOR of the fifteen 4-bit groups of {VLAN key bits 11:0, MAC key}, and it is taken when the command starts. Keys with equal folds share a bucket; keys with different folds do not.
- R8: While a command runs, bus writes to entry registers and to the control register are ignored. This includes a write to a bin in the same cycle that the bin is fetched, where the fetched value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data, aligned to register bit 0 |
| bus_be | input | 8 | Byte enables for bus_wdata |
| bus_rdata | output | 64 | Read data, one cycle after bus_rd |

## Verification
The sequencer's fetch into an entry register can fall in the same cycle as a bus write to that same register. The bench provokes this by issuing entry-register writes right after a read-command start. Some of these writes land on the very edge at which their bin is fetched, and one lands after its bin has already been fetched. The bench reads the registers afterwards and judges them against the fetched bucket contents: any write that got through would show up, whereas a correct design shows only the fetched values.

// File: rtl/mtbl_pkg.sv
package mtbl_pkg;

    localparam int BUS_W = 64;
    localparam int BE_W  = BUS_W / 8;
    localparam int MAC_W = 48;
    localparam int VID_W = 12;
    localparam int KEY_W = 64;
    localparam int DAT_W = 32;

    localparam logic [KEY_W-1:0] KEY_MASK  = 64'h0FFF_FFFF_FFFF_FFFF;
    localparam logic [DAT_W-1:0] DATA_MASK = 32'h0001_D9FF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE
    } seq_state_t;

    function automatic logic [BUS_W-1:0] be_merge(
        input logic [BUS_W-1:0] old_v,
        input logic [BUS_W-1:0] new_v,
        input logic [BE_W-1:0]  be
    );
        logic [BUS_W-1:0] res;
        for (int i = 0; i < BE_W; i++) begin
            res[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/mtbl_hash.sv
module mtbl_hash #(
    parameter int MAC_W = 48,
    parameter int VID_W = 12,
    parameter int IDX_W = 4
) (
    input  logic [MAC_W-1:0] mac,
    input  logic [VID_W-1:0] vid,
    output logic [IDX_W-1:0] idx
);
    localparam int IN_W   = MAC_W + VID_W;
    localparam int CHUNKS = (IN_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0] padded;

    assign padded = PAD_W'({vid, mac});

    always_comb begin
        idx = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            idx = idx ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/mtbl_seq.sv
module mtbl_seq
    import mtbl_pkg::*;
#(
    parameter int BINS  = 4,
    parameter int SEL_W = (BINS > 1) ? $clog2(BINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_rd,
    output logic             busy,
    output logic [SEL_W-1:0] bin_sel,
    output logic             fetch_en,
    output logic             store_en
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(BINS - 1);

    seq_state_t       state_q, state_d;
    logic [SEL_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = op_rd ? ST_FETCH : ST_STORE;
            ST_FETCH: if (cnt_q == LAST) state_d = ST_IDLE;
            ST_STORE: if (cnt_q == LAST) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy     = 1'b0;
        fetch_en = 1'b0;
        store_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin busy = 1'b1; fetch_en = 1'b1; end
            ST_STORE: begin busy = 1'b1; store_en = 1'b1; end
            default:  ;
        endcase
    end

    assign bin_sel = cnt_q;
endmodule

// File: rtl/mtbl_bucket_mem.sv
module mtbl_bucket_mem
    import mtbl_pkg::*;
#(
    parameter int BUCKETS = 16,
    parameter int BINS    = 4,
    parameter int IDX_W   = $clog2(BUCKETS),
    parameter int SEL_W   = (BINS > 1) ? $clog2(BINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] bucket,
    input  logic [SEL_W-1:0] bin_sel,
    input  logic             we,
    input  logic [KEY_W-1:0] wkey,
    input  logic [DAT_W-1:0] wdat,
    output logic [KEY_W-1:0] rkey,
    output logic [DAT_W-1:0] rdat
);
    localparam int DEPTH = BUCKETS * BINS;
    localparam int AW    = $clog2(DEPTH);

    logic [KEY_W-1:0] key_mem [DEPTH];
    logic [DAT_W-1:0] dat_mem [DEPTH];
    logic [AW-1:0]    addr;

    assign addr = AW'(bucket) * AW'(BINS) + AW'(bin_sel);
    assign rkey = key_mem[addr];
    assign rdat = dat_mem[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                key_mem[i] <= '0;
                dat_mem[i] <= '0;
            end
        end else if (we) begin
            key_mem[addr] <= wkey;
            dat_mem[addr] <= wdat;
        end
    end
endmodule

// File: rtl/mac_tbl_engine.sv
module mac_tbl_engine
    import mtbl_pkg::*;
#(
    parameter int BINS  = 4,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]  bus_be,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int   BUCKETS   = 1 << IDX_W;
    localparam int   SEL_W     = (BINS > 1) ? $clog2(BINS) : 1;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_MAC  = 8'h02;
    localparam logic [7:0] A_VLAN = 8'h08;

    function automatic logic [7:0] key_addr(input int n);
        return 8'((n + 1) * 16);
    endfunction

    function automatic logic [7:0] dat_addr(input int n);
        return 8'((n + 1) * 16 + 8);
    endfunction

    logic             ctrl_op;
    logic [MAC_W-1:0] mac_key;
    logic [15:0]      vlan_key;
    logic [KEY_W-1:0] bin_key  [BINS];
    logic [DAT_W-1:0] bin_dat  [BINS];
    logic [IDX_W-1:0] bucket_q;
    logic [IDX_W-1:0] hash_idx;
    logic             busy, fetch_en, store_en, start_cmd;
    logic [SEL_W-1:0] bin_sel;
    logic [KEY_W-1:0] mem_rkey;
    logic [DAT_W-1:0] mem_rdat;
    logic [BUS_W-1:0] rd_mux;
    logic             ctrl_wr;

    assign ctrl_wr   = bus_wr && !busy && (bus_addr == A_CTRL) && bus_be[0];
    assign start_cmd = ctrl_wr && bus_wdata[7];

    mtbl_hash #(.MAC_W(MAC_W), .VID_W(VID_W), .IDX_W(IDX_W)) u_hash (
        .mac (mac_key),
        .vid (vlan_key[VID_W-1:0]),
        .idx (hash_idx)
    );

    mtbl_seq #(.BINS(BINS), .SEL_W(SEL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_cmd),
        .op_rd    (bus_wdata[0]),
        .busy     (busy),
        .bin_sel  (bin_sel),
        .fetch_en (fetch_en),
        .store_en (store_en)
    );

    mtbl_bucket_mem #(.BUCKETS(BUCKETS), .BINS(BINS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .bucket  (bucket_q),
        .bin_sel (bin_sel),
        .we      (store_en),
        .wkey    (bin_key[bin_sel]),
        .wdat    (bin_dat[bin_sel]),
        .rkey    (mem_rkey),
        .rdat    (mem_rdat)
    );

    // control, key and bucket registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_op  <= 1'b0;
            mac_key  <= '0;
            vlan_key <= '0;
            bucket_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_op <= bus_wdata[0];
            if (start_cmd) bucket_q <= hash_idx;
            if (bus_wr && bus_addr == A_MAC)
                mac_key <= MAC_W'(be_merge(BUS_W'(mac_key), bus_wdata, bus_be));
            if (bus_wr && bus_addr == A_VLAN)
                vlan_key <= 16'(be_merge(BUS_W'(vlan_key), bus_wdata, bus_be));
        end
    end

    // per-bin entry registers
    generate
        for (genvar n = 0; n < BINS; n++) begin : g_bin
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bin_key[n] <= '0;
                    bin_dat[n] <= '0;
                end else if (fetch_en && bin_sel == SEL_W'(n)) begin
                    bin_key[n] <= mem_rkey;
                    bin_dat[n] <= mem_rdat;
                end else if (bus_wr && !busy) begin
                    if (bus_addr == key_addr(n))
                        bin_key[n] <= be_merge(bin_key[n], bus_wdata, bus_be) & KEY_MASK;
                    if (bus_addr == dat_addr(n))
                        bin_dat[n] <= DAT_W'(be_merge(BUS_W'(bin_dat[n]), bus_wdata, bus_be)) & DATA_MASK;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_CTRL) rd_mux = BUS_W'({busy, 6'b0, ctrl_op});
        if (bus_addr == A_MAC)  rd_mux = BUS_W'(mac_key);
        if (bus_addr == A_VLAN) rd_mux = BUS_W'(vlan_key);
        for (int n = 0; n < BINS; n++) begin
            if (bus_addr == key_addr(n)) rd_mux = bin_key[n];
            if (bus_addr == dat_addr(n)) rd_mux = BUS_W'(bin_dat[n]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/mtbl_checker.sv
module mtbl_checker #(
    parameter int BINS  = 4,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             be0,
    input logic             start_bit,
    input logic [63:0]      bus_rdata,
    input logic             busy,
    input logic [SEL_W-1:0] bin_sel
);
    localparam logic [SEL_W-1:0] LAST     = SEL_W'(BINS - 1);
    localparam logic [7:0]       TOP_ADDR = 8'(BINS * 16 + 8);

    logic start_req, bin_region, key_rd, dat_rd;

    assign start_req  = bus_wr && bus_addr == 8'h00 && be0 && start_bit;
    assign bin_region = (bus_addr[7:4] != 4'h0) && (int'(bus_addr[7:4]) <= BINS);
    assign key_rd     = bus_rd && bin_region && bus_addr[3:0] == 4'h0;
    assign dat_rd     = bus_rd && bin_region && bus_addr[3:0] == 4'h8;

    AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> busy);  // R4
    AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bin_sel != LAST) |=> (busy && bin_sel == SEL_W'($past(bin_sel) + 1'b1)));  // R4
    AST_CMD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bin_sel == LAST) |=> !busy);  // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bin_sel == LAST && start_req) |=> !busy);  // R8
    AST_KEY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        key_rd |=> bus_rdata[63:60] == 4'h0);  // R3
    AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd |=> (bus_rdata & ~64'h0001_D9FF) == 64'h0);  // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > TOP_ADDR) |=> bus_rdata == 64'h0);  // R2
endmodule

bind mac_tbl_engine mtbl_checker #(.BINS(BINS), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .be0       (bus_be[0]),
    .start_bit (bus_wdata[7]),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .bin_sel   (bin_sel)
);

// File: tb/mac_tbl_engine_test.sv
module mac_tbl_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [7:0]  bus_be = '0;
    logic [63:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic rd_seen = 1'b0;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    mac_tbl_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata)
    );

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [63:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_key(input logic [47:0] m, input logic [15:0] v);
        wr(8'h02, {16'h0, m}, 8'hFF);
        wr(8'h08, {48'h0, v}, 8'h03);
    endtask

    task automatic cmd(input logic op_rd);
        wr(8'h00, {56'h0, 1'b1, 6'b0, op_rd}, 8'h01);
        idle(6);
    endtask

    function automatic logic [7:0] ka(input int n); return 8'(n * 16);     endfunction
    function automatic logic [7:0] da(input int n); return 8'(n * 16 + 8); endfunction
    function automatic logic [63:0] kv(input int n); return 64'h0005_0011_2233_4450 + 64'(n); endfunction
    function automatic logic [63:0] dv(input int n);
        return (n == 4) ? 64'h0001_C804 : (64'h0001_0000 | 64'(n));
    endfunction

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(8'h00, 64'h0, "R1 ctrl after reset");
        rd(ka(2), 64'h0, "R1 bin key after reset");
        set_key(48'h0011_2233_4455, 16'h0005);
        cmd(1'b1);
        for (int n = 1; n <= 4; n++) rd(da(n), 64'h0, "R1 table empty after reset");

        // R2 byte enables and map
        wr(8'h02, 64'h0000_0000_0000_BB00, 8'h02);
        rd(8'h02, 64'h0000_0011_2233_BB55, "R2 MAC byte enable merge");
        wr(8'h02, 64'hFFFF_0011_2233_4455, 8'hFF);
        rd(8'h02, 64'h0000_0011_2233_4455, "R2 MAC width limit");
        wr(8'h08, 64'h1234_5678_9ABC_DEF0, 8'h03);
        rd(8'h08, 64'h0000_0000_0000_DEF0, "R2 VLAN width limit");
        wr(8'h08, 64'h5, 8'h03);
        rd(8'h60, 64'h0, "R2 unmapped address");

        // R3 field masks
        wr(ka(2), 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        rd(ka(2), 64'h0FFF_FFFF_FFFF_FFFF, "R3 key word mask");
        wr(da(2), 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        rd(da(2), 64'h0000_0000_0001_D9FF, "R3 data word mask");

        // R6 write command then read back
        for (int n = 1; n <= 4; n++) begin
            wr(ka(n), kv(n), 8'hFF);
            wr(da(n), dv(n), 8'hFF);
        end
        cmd(1'b0);
        rd(8'h00, 64'h0, "R4 ctrl after write command");
        for (int n = 1; n <= 4; n++) begin
            wr(ka(n), 64'h0, 8'hFF);
            wr(da(n), 64'h0, 8'hFF);
        end

        // R4 busy window during a read command
        wr(8'h00, 64'h81, 8'h01);
        for (int i = 0; i < 4; i++) rd(8'h00, 64'h81, "R4 busy during command");
        rd(8'h00, 64'h01, "R4 busy cleared after four cycles");
        idle(2);
        // R5 bucket copied into entry registers
        for (int n = 1; n <= 4; n++) begin
            rd(ka(n), kv(n), "R5 fetched key word");
            rd(da(n), dv(n), "R5 fetched data word");
        end

        // R7 different key, same fold 5
        for (int n = 1; n <= 4; n++) wr(da(n), 64'h0, 8'hFF);
        set_key(48'h0000_0000_0005, 16'h0000);
        cmd(1'b1);
        rd(da(3), dv(3), "R7 equal fold shares bucket");
        rd(ka(4), kv(4), "R7 equal fold shares bucket key");

        // R7/R8 different fold 6, collisions while busy
        set_key(48'h0000_0000_0006, 16'h0000);
        wr(8'h00, 64'h81, 8'h01);
        wr(da(1), 64'h0001_0003, 8'hFF);  // same edge as bin 1 fetch
        wr(da(2), 64'h0001_0003, 8'hFF);  // same edge as bin 2 fetch
        wr(da(1), 64'h0001_0007, 8'hFF);  // after bin 1 fetch
        wr(8'h00, 64'h00, 8'h01);         // control write while busy
        idle(3);
        rd(da(1), 64'h0, "R8 bin write during fetch ignored");
        rd(da(2), 64'h0, "R8 bin write on fetch edge ignored");
        rd(ka(3), 64'h0, "R7 different fold empty bucket");
        rd(8'h00, 64'h01, "R8 ctrl write while busy ignored");

        // R6 delete by clearing valid
        set_key(48'h0011_2233_4455, 16'h0005);
        cmd(1'b1);
        wr(da(2), 64'h0000_0002, 8'hFF);
        cmd(1'b0);
        wr(da(2), 64'h0001_01FF, 8'hFF);
        cmd(1'b1);
        rd(da(2), 64'h0000_0002, "R6 deleted bin invalid");
        rd(da(1), dv(1), "R6 other bin kept");

        idle(3);
        finish_run();
    end
endmodule